// File: doc/BRIEF.md
# Crypto Feed Interrupt Aggregator

This block gathers the completion events of a crypto feed unit's four DMA channels into one level interrupt. Each channel signals that it is done with a single-cycle pulse. The block holds that event in a sticky status bit, and each status bit has its own enable bit. The interrupt output is high while any enabled status bit is set.

Software reaches the block through a simple word-wide read/write port. The enable mask has no plain write. Bits are turned on through one offset and turned off through another, so one driver can change a single source without a read-modify-write. A typical job runs like this: software turns off the two block-cipher sources, programs both DMA channels and turns the two sources back on. When the interrupt fires, it reads the status word and writes that same word to the acknowledge offset. Only the events it saw are cleared, and an event that arrives in the meantime is kept.

Top module: `feed_irq_ctrl`

## Requirements
- R1: After reset, every status bit, every enable bit, `irq_o` and `bus_rdata` are zero. Reading any register then returns zero.
- R2: A pulse on `evt_i[k]` sets status bit k, and the bit stays set until it is acknowledged. The bits are: 3 = block-cipher receive DMA done, 2 = block-cipher transmit DMA done, 1 = hash receive DMA done, 0 = public-key DMA done. A read of offset 0x00 returns the status in bits 3:0.
- R3: A write to offset 0x0C clears exactly the status bits that are one in `bus_wdata[3:0]`. All other status bits keep their value.
- R4: If an event pulse and an acknowledge reach the same status bit in the same cycle, the bit ends up set.
- R5: A write to offset 0x04 sets every enable bit whose `bus_wdata` bit is one. Zero bits leave their enable bits unchanged.
- R6: A write to offset 0x08 clears every enable bit whose `bus_wdata` bit is one. Zero bits leave their enable bits unchanged.
- R7: A read of offset 0x04 or 0x08 returns the enable mask in bits 3:0. A read of offset 0x0C returns status AND enable. Bits 31:4 of every read are zero.
- R8: `irq_o` is registered. It is high in the cycle after some status bit and its enable bit are both one, and low in the cycle after no such pair exists.
- R9: A write to offset 0x00 changes nothing. Write data bits 31:4 are ignored. A read of any offset other than 0x00, 0x04, 0x08 and 0x0C returns zero.
- R10: `bus_rdata` is registered. It updates one clock after a read request (`bus_sel` high, `bus_wr` low) and holds its value in every cycle that has no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 4 | Single-cycle completion pulses, one per DMA source |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions check on every cycle that status bits are sticky, that a same-cycle event overrides an acknowledge, and that set and clear writes touch only their selected enable bits. They also check that the interrupt stays low when no enabled source is pending and that read data holds between reads. Only the bench scenarios can show the software-visible sequences. These include the exact encoding each offset returns, a write to the status offset having no effect, unmapped reads returning zero, the one-cycle interrupt latency and the acknowledge-by-writeback flow across several masks.

// File: rtl/fic_pkg.sv
package fic_pkg;

    // Byte offsets of the register window; driver code relies on these.
    localparam int unsigned OFF_STATUS = 32'h00;
    localparam int unsigned OFF_EN_SET = 32'h04;
    localparam int unsigned OFF_EN_CLR = 32'h08;
    localparam int unsigned OFF_ACK    = 32'h0C;

    // One-hot register select produced by the decoder.
    typedef struct packed {
        logic status;
        logic en_set;
        logic en_clr;
        logic ack;
    } hit_t;

endpackage

// File: rtl/fic_decode.sv
module fic_decode
    import fic_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [NUM_SRC-1:0] set_bits,
    output logic [NUM_SRC-1:0] clr_bits,
    output logic [NUM_SRC-1:0] ack_bits,
    output logic              rd_stb,
    output hit_t              rd_hit
);

    hit_t hit;
    logic wr_stb;

    // Only the low NUM_SRC data bits carry meaning (R9).
    logic unused_upper;
    assign unused_upper = ^bus_wdata[DATA_W-1:NUM_SRC];

    always_comb begin
        hit.status = (bus_addr == ADDR_W'(OFF_STATUS));
        hit.en_set = (bus_addr == ADDR_W'(OFF_EN_SET));
        hit.en_clr = (bus_addr == ADDR_W'(OFF_EN_CLR));
        hit.ack    = (bus_addr == ADDR_W'(OFF_ACK));

        wr_stb   = bus_sel && bus_wr;
        rd_stb   = bus_sel && !bus_wr;
        rd_hit   = hit;

        set_bits = (wr_stb && hit.en_set) ? bus_wdata[NUM_SRC-1:0] : '0;
        clr_bits = (wr_stb && hit.en_clr) ? bus_wdata[NUM_SRC-1:0] : '0;
        ack_bits = (wr_stb && hit.ack)    ? bus_wdata[NUM_SRC-1:0] : '0;
    end

endmodule

// File: rtl/fic_status.sv
module fic_status #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [NUM_SRC-1:0] ack_i,
    output logic [NUM_SRC-1:0] status_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] status;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Clear acknowledged bits first, then let new events override.
        st_d.status = (st_q.status & ~ack_i) | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;

    // R2: a set bit that is not acknowledged stays set.
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(st_q.status & ~ack_i)) |=>
            ((st_q.status & $past(st_q.status & ~ack_i)) == $past(st_q.status & ~ack_i)));

    // R4: an event always lands, even when acknowledged in the same cycle.
    p_evt_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((st_q.status & $past(evt_i)) == $past(evt_i)));

    // R3: acknowledged bits without a new event are cleared.
    p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ack_i & ~evt_i)) |=> ((st_q.status & $past(ack_i & ~evt_i)) == '0));

endmodule

// File: rtl/fic_mask.sv
module fic_mask #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] en_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
    } mk_t;

    mk_t mk_d, mk_q;

    always_comb begin
        mk_d = mk_q;
        // Set and clear live at different offsets; clear is applied last.
        mk_d.en = (mk_q.en | set_i) & ~clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mk_q <= '0;
        else        mk_q <= mk_d;
    end

    assign en_o = mk_q.en;

    // R5: ones written to the set offset turn their bits on.
    p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((mk_q.en & $past(set_i)) == $past(set_i)));

    // R6: ones written to the clear offset turn their bits off.
    p_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_i) |=> ((mk_q.en & $past(clr_i)) == '0));

    // R5, R6: without set or clear bits the mask does not move.
    p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0 && clr_i == '0) |=> $stable(mk_q.en));

endmodule

// File: rtl/fic_readback.sv
module fic_readback
    import fic_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_stb,
    input  hit_t               rd_hit,
    input  logic [NUM_SRC-1:0] status_i,
    input  logic [NUM_SRC-1:0] en_i,
    output logic [DATA_W-1:0]  rdata_o
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rb_t;

    rb_t rb_d, rb_q;

    always_comb begin
        rb_d = rb_q;
        if (rd_stb) begin
            if (rd_hit.status)
                rb_d.rdata = DATA_W'(status_i);
            else if (rd_hit.en_set || rd_hit.en_clr)
                rb_d.rdata = DATA_W'(en_i);
            else if (rd_hit.ack)
                rb_d.rdata = DATA_W'(status_i & en_i);
            else
                rb_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rb_q <= '0;
        else        rb_q <= rb_d;
    end

    assign rdata_o = rb_q.rdata;

    // R10: read data holds through cycles without a read.
    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rb_q.rdata));

    // R7: nothing above the source bits is ever returned.
    p_rd_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rb_q.rdata[DATA_W-1:NUM_SRC] == '0);

endmodule

// File: rtl/feed_irq_ctrl.sv
module feed_irq_ctrl
    import fic_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o
);

    logic [NUM_SRC-1:0] set_bits, clr_bits, ack_bits;
    logic [NUM_SRC-1:0] status, en;
    logic               rd_stb;
    hit_t               rd_hit;

    fic_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .set_bits  (set_bits),
        .clr_bits  (clr_bits),
        .ack_bits  (ack_bits),
        .rd_stb    (rd_stb),
        .rd_hit    (rd_hit)
    );

    fic_status #(.NUM_SRC(NUM_SRC)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .ack_i    (ack_bits),
        .status_o (status)
    );

    fic_mask #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_bits),
        .clr_i (clr_bits),
        .en_o  (en)
    );

    fic_readback #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_readback (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_stb   (rd_stb),
        .rd_hit   (rd_hit),
        .status_i (status),
        .en_i     (en),
        .rdata_o  (bus_rdata)
    );

    typedef struct packed {
        logic irq;
    } top_t;

    top_t top_d, top_q;

    always_comb begin
        top_d     = top_q;
        top_d.irq = |(status & en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign irq_o = top_q.irq;

    // R8: with no enabled pending source the line is low next cycle.
    p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & en) == '0) |=> !irq_o);

endmodule

// File: tb/feed_irq_ctrl_tb.sv
module feed_irq_ctrl_tb;

    localparam int NS = 4;
    localparam int AW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] evt = '0;
    logic          sel = 1'b0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    feed_irq_ctrl #(.NUM_SRC(NS), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .bus_sel   (sel),
        .bus_wr    (wr),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq_o     (irq)
    );

    typedef struct packed {
        logic [3:0]  evt;
        logic        wr;
        logic [7:0]  waddr;
        logic [31:0] wdata;
        logic [7:0]  raddr;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    // Each step: optional event pulse and write in one cycle, one idle cycle,
    // irq check, then a read of raddr checked against exp_rd.
    localparam vec_t VECS [NV] = '{
        '{4'h8, 1'b0, 8'h00, 32'h0,        8'h00, 32'h8, 1'b0, 4'd2},  // R2 bit3 latches, masked
        '{4'h0, 1'b1, 8'h04, 32'hC,        8'h0C, 32'h8, 1'b1, 4'd5},  // R5 enable 3,2; R7 pending
        '{4'h1, 1'b0, 8'h00, 32'h0,        8'h00, 32'h9, 1'b1, 4'd2},  // R2 second source
        '{4'h0, 1'b1, 8'h0C, 32'h8,        8'h0C, 32'h0, 1'b0, 4'd3},  // R3 ack bit3 only
        '{4'h0, 1'b1, 8'h04, 32'h1,        8'h04, 32'hD, 1'b1, 4'd5},  // R5 zeros keep bits
        '{4'h0, 1'b1, 8'h08, 32'h4,        8'h08, 32'h9, 1'b1, 4'd6},  // R6 clear bit2 only
        '{4'h4, 1'b1, 8'h0C, 32'h4,        8'h00, 32'h5, 1'b1, 4'd4},  // R4 event beats ack
        '{4'h0, 1'b1, 8'h00, 32'hF,        8'h00, 32'h5, 1'b1, 4'd9},  // R9 status write ignored
        '{4'h0, 1'b1, 8'h08, 32'hFFFFFFF1, 8'h04, 32'h8, 1'b0, 4'd6},  // R6 clear bit0
        '{4'h0, 1'b1, 8'h0C, 32'h5,        8'h00, 32'h0, 1'b0, 4'd3},  // R3 writeback ack
        '{4'hF, 1'b0, 8'h00, 32'h0,        8'h0C, 32'h8, 1'b1, 4'd7},  // R7 pending = st & en
        '{4'h0, 1'b0, 8'h00, 32'h0,        8'h10, 32'h0, 1'b1, 4'd9},  // R9 unmapped read
        '{4'h0, 1'b1, 8'h0C, 32'hF,        8'h00, 32'h0, 1'b0, 4'd3},  // R3 ack all
        '{4'h0, 1'b1, 8'h04, 32'hF0,       8'h04, 32'h8, 1'b0, 4'd9}   // R9 upper data ignored
    };

    task automatic check(input string what, input int req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic read_reg(input logic [7:0] a);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        @(posedge clk); #1;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        evt = v.evt; sel = v.wr; wr = v.wr; addr = v.waddr; wdata = v.wdata;
        @(negedge clk);
        evt = '0; sel = 1'b0; wr = 1'b0;
        @(posedge clk); #1;
        check("irq", int'(v.req), 32'(irq), 32'(v.exp_irq));
        read_reg(v.raddr);
        check("rdata", int'(v.req), rdata, v.exp_rd);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("reset irq", 1, 32'(irq), 32'h0);
        check("reset rdata", 1, rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        read_reg(8'h00);
        check("reset status", 1, rdata, 32'h0);
        read_reg(8'h04);
        check("reset enable", 1, rdata, 32'h0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R8: registered interrupt lags the status bit by one cycle.
        @(negedge clk);
        evt = 4'h8;
        @(posedge clk); #1;
        check("irq before lag", 8, 32'(irq), 32'h0);
        @(negedge clk);
        evt = '0;
        @(posedge clk); #1;
        check("irq after lag", 8, 32'(irq), 32'h1);

        // R10: read data holds across a write with no read.
        read_reg(8'h04);
        check("read enable", 10, rdata, 32'h8);
        write_reg(8'h04, 32'h0);
        write_reg(8'h0C, 32'h8);
        check("rdata hold", 10, rdata, 32'h8);
        @(posedge clk); #1;
        check("irq drop after ack", 8, 32'(irq), 32'h0);

        // R1: reset in mid-run clears everything.
        write_reg(8'h04, 32'hF);
        @(negedge clk);
        evt = 4'hF;
        @(negedge clk);
        evt = '0;
        @(posedge clk); #1;
        check("irq before reset", 8, 32'(irq), 32'h1);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("irq in reset", 1, 32'(irq), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        read_reg(8'h00);
        check("status after reset", 1, rdata, 32'h0);
        read_reg(8'h08);
        check("enable after reset", 1, rdata, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule